// File: doc/BRIEF.md
# Selectable-Polynomial 32-bit Signature Register

This block is a 32-bit linear feedback shift register. It can compress a serial scan stream into a signature, or it can run with a zero input to produce pseudo-random patterns. Software programs it through a 16-bit register bus. It picks one of three fixed feedback polynomials with a small select code, loads a 32-bit starting value, and reads back the 32-bit state.

Each 32-bit quantity is carried by two 16-bit registers that software accesses back to back. A seed write is held until its upper half arrives, and then the whole value is loaded in one step. A result read takes a snapshot of the state when the lower half is read, so the upper half that follows belongs to the same instant even if shifting went on between the two reads.

The register is a Galois-form left shifter. On every enabled shift, the feedback bit is the old bit 31 XOR the serial input. When the feedback bit is 1, the tap mask of the selected polynomial is XORed into the shifted value.

Top module: `sig_lfsr_top`

## Requirements
- R1: After reset, every register address (0 to 4) reads back 0x0000. The shift state and the captured upper half are zero.
- R2: Address 0 is the select register. Its code sits in bits 2:0. Bits 15:3 read as zero whatever was written to them.
- R3: With select code 0, or any code from 4 to 7, the shift state holds its value even when shift_en is high.
- R4: Codes 1, 2 and 3 use the tap masks 0x000000AF (x^32+x^7+x^5+x^3+x^2+x+1), 0x18000003 (x^32+x^28+x^27+x+1) and 0x000000C5 (x^32+x^7+x^6+x^2+1). One shift computes next = {state[30:0],0} XOR (fb ? mask : 0). When shift_en is low the state holds.
- R5: The feedback bit fb equals state[31] XOR scan_in. A zero state with scan_in at 0 stays zero.
- R6: Writing address 1 (lower seed word) only stages the value. The shift state is not changed by that write, and the staged word reads back at address 1.
- R7: Writing address 2 (upper seed word) loads the shift state with {write data, staged lower word} on the next clock edge. A load in the same cycle as a shift wins over the shift. The written word reads back at address 2.
- R8: A read strobe at address 3 returns state[15:0] in that cycle and captures state[31:16].
- R9: Address 4 returns the captured upper half, even if the state has shifted since the capture. Writes to addresses 3 and 4 change nothing, and unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| bus_addr | input | 3 | Register address |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe (arms the capture at address 3) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| shift_en | input | 1 | Enables one shift per clock |
| scan_in | input | 1 | Serial data compressed into the signature |

## Verification
The bench runs every select code, including the unused codes 4 to 7, from several seeds with a varied serial stream. A wrong tap mask or a feedback that left out the serial input would show up as a different signature. An inactive code that still shifted would change the result. The pairing corners get their own checks:
- A lower seed write that loaded the state too early would show up in the result.
- A capture that missed the shifts between the two result reads would return a drifted upper half.
- A design that let a shift override a seed load in the same cycle would be caught.

The bench also writes to the reserved select bits and to the read-only addresses, and then reads them back.

// File: rtl/sig_lfsr_pkg.sv
package sig_lfsr_pkg;
    localparam int unsigned STATE_W = 32;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned CODE_W  = 3;
    localparam int unsigned ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_SEL     = 3'd0;
    localparam logic [ADDR_W-1:0] A_SEED_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_SEED_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_RES_LO  = 3'd3;
    localparam logic [ADDR_W-1:0] A_RES_HI  = 3'd4;

    localparam logic [STATE_W-1:0] TAPS_A = 32'h0000_00AF;
    localparam logic [STATE_W-1:0] TAPS_B = 32'h1800_0003;
    localparam logic [STATE_W-1:0] TAPS_C = 32'h0000_00C5;

    function automatic logic [STATE_W-1:0] tap_mask(input logic [CODE_W-1:0] code);
        case (code)
            3'd1:    return TAPS_A;
            3'd2:    return TAPS_B;
            3'd3:    return TAPS_C;
            default: return '0;
        endcase
    endfunction

    function automatic logic code_active(input logic [CODE_W-1:0] code);
        return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
    endfunction
endpackage

// File: rtl/sig_lfsr_regs.sv
module sig_lfsr_regs
    import sig_lfsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WORD_W-1:0]  wdata,
    output logic [CODE_W-1:0]  sel_code,
    output logic [WORD_W-1:0]  seed_lo,
    output logic [WORD_W-1:0]  seed_hi,
    output logic               load_go,
    output logic [STATE_W-1:0] load_val
);
    typedef struct packed {
        logic [CODE_W-1:0] sel;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (addr)
                A_SEL:     cfg_d.sel = wdata[CODE_W-1:0];
                A_SEED_LO: cfg_d.lo  = wdata;
                A_SEED_HI: cfg_d.hi  = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign sel_code = cfg_q.sel;
    assign seed_lo  = cfg_q.lo;
    assign seed_hi  = cfg_q.hi;
    assign load_go  = wr_en && (addr == A_SEED_HI);
    assign load_val = {wdata, cfg_q.lo};
endmodule

// File: rtl/sig_lfsr_core.sv
module sig_lfsr_core
    import sig_lfsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  sel_code,
    input  logic               load_go,
    input  logic [STATE_W-1:0] load_val,
    input  logic               shift_en,
    input  logic               scan_in,
    output logic [STATE_W-1:0] state
);
    typedef struct packed {
        logic [STATE_W-1:0] sr;
    } core_t;

    core_t core_d, core_q;
    logic  fb;

    always_comb begin
        core_d = core_q;
        fb     = core_q.sr[STATE_W-1] ^ scan_in;
        if (load_go) begin
            core_d.sr = load_val;
        end else if (shift_en && code_active(sel_code)) begin
            core_d.sr = {core_q.sr[STATE_W-2:0], 1'b0} ^ (fb ? tap_mask(sel_code) : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign state = core_q.sr;
endmodule

// File: rtl/sig_lfsr_rdmux.sv
module sig_lfsr_rdmux
    import sig_lfsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [STATE_W-1:0] state,
    input  logic [CODE_W-1:0]  sel_code,
    input  logic [WORD_W-1:0]  seed_lo,
    input  logic [WORD_W-1:0]  seed_hi,
    output logic [WORD_W-1:0]  rdata,
    output logic [WORD_W-1:0]  snap_hi
);
    localparam int unsigned PAD_W = WORD_W - CODE_W;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
    } snap_t;

    snap_t snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (rd_en && (addr == A_RES_LO)) snap_d.hi = state[STATE_W-1:WORD_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    always_comb begin
        case (addr)
            A_SEL:     rdata = {{PAD_W{1'b0}}, sel_code};
            A_SEED_LO: rdata = seed_lo;
            A_SEED_HI: rdata = seed_hi;
            A_RES_LO:  rdata = state[WORD_W-1:0];
            A_RES_HI:  rdata = snap_q.hi;
            default:   rdata = '0;
        endcase
    end

    assign snap_hi = snap_q.hi;
endmodule

// File: rtl/sig_lfsr_top.sv
module sig_lfsr_top
    import sig_lfsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              shift_en,
    input  logic              scan_in
);
    logic [CODE_W-1:0]  sel_code;
    logic [WORD_W-1:0]  seed_lo;
    logic [WORD_W-1:0]  seed_hi;
    logic               load_go;
    logic [STATE_W-1:0] load_val;
    logic [STATE_W-1:0] state;
    logic [WORD_W-1:0]  snap_hi;

    sig_lfsr_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr_en),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .sel_code (sel_code),
        .seed_lo  (seed_lo),
        .seed_hi  (seed_hi),
        .load_go  (load_go),
        .load_val (load_val)
    );

    sig_lfsr_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_code (sel_code),
        .load_go  (load_go),
        .load_val (load_val),
        .shift_en (shift_en),
        .scan_in  (scan_in),
        .state    (state)
    );

    sig_lfsr_rdmux u_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (bus_rd_en),
        .addr     (bus_addr),
        .state    (state),
        .sel_code (sel_code),
        .seed_lo  (seed_lo),
        .seed_hi  (seed_hi),
        .rdata    (bus_rdata),
        .snap_hi  (snap_hi)
    );
endmodule

// File: rtl/sig_lfsr_chk.sv
module sig_lfsr_chk
    import sig_lfsr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr_en,
    input logic               bus_rd_en,
    input logic [WORD_W-1:0]  bus_wdata,
    input logic [WORD_W-1:0]  bus_rdata,
    input logic               shift_en,
    input logic [CODE_W-1:0]  sel_code,
    input logic [WORD_W-1:0]  seed_lo,
    input logic [STATE_W-1:0] state,
    input logic [WORD_W-1:0]  snap_hi
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_SEL) |-> (bus_rdata[WORD_W-1:CODE_W] == '0));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_wr_en && bus_addr == A_SEED_HI) && !code_active(sel_code)) |=> $stable(state));

    a_r4_no_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_wr_en && bus_addr == A_SEED_HI) && !shift_en) |=> $stable(state));

    a_r6_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == A_SEED_LO && !shift_en) |=> $stable(state));

    a_r7_pair_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == A_SEED_HI) |=> (state == {$past(bus_wdata), $past(seed_lo)}));

    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == A_RES_LO) |=> (snap_hi == $past(state[STATE_W-1:WORD_W])));

    a_r9_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_en && bus_addr == A_RES_LO) |=> $stable(snap_hi));
endmodule

bind sig_lfsr_top sig_lfsr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .shift_en  (shift_en),
    .sel_code  (sel_code),
    .seed_lo   (seed_lo),
    .state     (state),
    .snap_hi   (snap_hi)
);

// File: tb/sig_lfsr_top_tb.sv
`timescale 1ns/1ps
module sig_lfsr_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        shift_en = 1'b0;
    logic        scan_in = 1'b0;

    int errors = 0;
    int checks = 0;
    logic [31:0] model;
    logic [2:0]  cur_code;

    always #10 clk = ~clk;

    sig_lfsr_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .shift_en(shift_en), .scan_in(scan_in)
    );

    function automatic logic [31:0] mask_of(input logic [2:0] c);
        case (c)
            3'd1: return 32'h0000_00AF;
            3'd2: return 32'h1800_0003;
            3'd3: return 32'h0000_00C5;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] step(input logic [31:0] s, input logic [2:0] c, input logic b);
        logic f;
        if (c == 3'd0 || c > 3'd3) return s;
        f = s[31] ^ b;
        return {s[30:0], 1'b0} ^ (f ? mask_of(c) : 32'h0);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic shift_n(input int n, input logic [31:0] pat);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            shift_en = 1'b1;
            scan_in  = pat[i % 32];
            model    = step(model, cur_code, pat[i % 32]);
        end
        @(negedge clk);
        shift_en = 1'b0; scan_in = 1'b0;
    endtask

    task automatic check_result(input string req);
        logic [15:0] lo, hi;
        rd(3'd3, lo);
        rd(3'd4, hi);
        chk(req, lo, model[15:0]);
        chk(req, hi, model[31:16]);
    endtask

    task automatic load_seed(input logic [31:0] s);
        wr(3'd1, s[15:0]);
        wr(3'd2, s[31:16]);
        model = s;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [31:0] snap;
        model = '0; cur_code = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values on every address
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1", v, 16'h0);
        end

        // R2 reserved bits of the select register
        wr(3'd0, 16'hFFFB);
        rd(3'd0, v);
        chk("R2", v, 16'h0003);

        // R4/R3 sweep over every code and several seeds
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 3; k++) begin
                logic [31:0] seed;
                seed = 32'h9E37_79B9 * (c * 3 + k + 1) ^ 32'h0F0F_1234;
                wr(3'd0, 16'(c));
                cur_code = 3'(c);
                load_seed(seed);
                shift_n(37 + k * 11, 32'hC3A5_0F96 ^ seed);
                if (c == 0 || c > 3) check_result("R3");
                else                 check_result("R4");
            end
        end

        // R5 zero state with zero input stays zero; one input bit injects the mask
        wr(3'd0, 16'd2); cur_code = 3'd2;
        load_seed(32'h0);
        shift_n(20, 32'h0);
        check_result("R5");
        shift_n(1, 32'h1);
        check_result("R5");

        // R6 lower seed write stages only, reads back
        wr(3'd1, 16'hBEEF);
        check_result("R6");
        rd(3'd1, v);
        chk("R6", v, 16'hBEEF);

        // R7 upper write loads pair; load beats a simultaneous shift
        wr(3'd1, 16'h1357);
        @(negedge clk);
        bus_addr = 3'd2; bus_wdata = 16'h2468; bus_wr_en = 1'b1;
        shift_en = 1'b1; scan_in = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; shift_en = 1'b0; scan_in = 1'b0;
        model = 32'h2468_1357;
        check_result("R7");
        rd(3'd2, v);
        chk("R7", v, 16'h2468);

        // R8/R9 capture on lower read holds across shifting
        wr(3'd0, 16'd1); cur_code = 3'd1;
        load_seed(32'hF00D_CAFE);
        shift_n(9, 32'h5A5A_5A5A);
        rd(3'd3, v);
        chk("R8", v, model[15:0]);
        snap = model;
        shift_n(23, 32'h1234_5678);
        rd(3'd4, v);
        chk("R9", v, snap[31:16]);
        check_result("R9");

        // R9 writes to result addresses and unused addresses
        snap = model;
        wr(3'd3, 16'hAAAA);
        wr(3'd4, 16'h5555);
        wr(3'd7, 16'hFFFF);
        check_result("R9");
        rd(3'd7, v);
        chk("R9", v, 16'h0);
        rd(3'd6, v);
        chk("R9", v, 16'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule